// File: doc/BRIEF.md
# SDRAM Start-up and Refresh Sequencer

This block drives the command and address pins of a single-data-rate SDRAM from reset onward. It first runs the fixed start-up order the memory needs: a long idle wait, one precharge of every bank, a train of auto-refresh commands and a mode register load. It then keeps the array alive by tracking how many refreshes are owed. One refresh falls due every `REF_IVL` cycles, so that 4096 of them fit in each 64 ms retention period.

Owed refreshes are offered to an outside arbiter through a request line. Each refresh is issued only when the arbiter grants the pins. A backlog of up to `MAX_OWED` refreshes is remembered, and the backlog drains back to back, spaced by the row cycle time. All waits are counted in clock cycles. The top takes them as parameters, with defaults derived from the clock rate.

Top module: `sdram_init_refresh`

## Requirements
- R1: While reset is held, and for the first `WAIT_CYC` cycles after it is released, the pins carry NOP ({csN,rasN,casN,weN} = 4'b0111), the address is zero, and both `initDone` and `refReq` are low.
- R2: In cycle `WAIT_CYC` after reset release, a precharge-all (4'b0010) appears with only address bit 10 set.
- R3: The start-up refreshes (4'b0001, address zero) number `INIT_REFS`. The first comes `TRP+1` cycles after the precharge, so `TRP` NOP cycles lie between them. Each later one follows the previous one by exactly `TRC` cycles.
- R4: A mode load (4'b0000) follows the last start-up refresh by `TRC` cycles. Address bits 6:0 and 9 carry the matching `modeWord` bits. Address bits 7, 8 and 10 and above are zero.
- R5: `initDone` rises exactly `TMRD` cycles after the mode load and stays high until reset. Only NOP appears in between.
- R6: `refGrant` has no effect before `initDone` rises.
- R7: `refReq` first rises `REF_IVL` cycles after `initDone` rises. Each further `REF_IVL` cycles adds one owed refresh.
- R8: `refReq` stays high while any refresh is owed. The owed count only falls through an accepted grant.
- R9: A grant is accepted when `refReq` is high and at least `TRC` cycles have passed since the previous refresh. An accepted grant puts a refresh on the pins in the next cycle and removes one owed refresh. A grant that fails either condition is ignored.
- R10: The owed count saturates at `MAX_OWED`. After many unserved periods, exactly `MAX_OWED` refreshes drain before `refReq` falls.
- R11: When a period ends in the same cycle that a grant is accepted, the owed count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| modeWord | input | 10 | Mode value to load (bits 7 and 8 are dropped) |
| refGrant | input | 1 | Arbiter grants the pins for a refresh |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (A0 upward) |
| initDone | output | 1 | Start-up sequence complete |
| refReq | output | 1 | At least one refresh is owed |

## Verification
Two events can land in the same cycle: the end of a refresh period, which adds to the owed count, and an accepted grant, which removes from it. The bench lets two periods pass without service. It then raises the grant for exactly the cycle in which the next period ends, computed from the rise of `initDone`. It then drains the backlog and counts the refreshes on the pins; three are expected. The saturation bound is checked the same way, after ten unserved periods, by counting exactly `MAX_OWED` drained refreshes.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  localparam int MODE_W = 10;
  localparam int AP_BIT = 10;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_RP,
    ST_RC,
    ST_MRD,
    ST_RUN
  } seq_state_e;

  localparam logic [1:0] TSEL_RP  = 2'd0;
  localparam logic [1:0] TSEL_RC  = 2'd1;
  localparam logic [1:0] TSEL_MRD = 2'd2;

  typedef struct packed {
    logic       issuePre;
    logic       issueRef;
    logic       issueMrs;
    logic       setDone;
    logic       ldTimer;
    logic [1:0] tmrSel;
    logic       initLoad;
    logic       initDec;
    logic       runEn;
    logic       takeRef;
  } seq_strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tmrZero,
  input  logic        initLast,
  input  logic        owedNz,
  input  logic        refGrant,
  output seq_strobe_t stb
);

  seq_state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_WAIT;
    else       stateQ <= stateD;
  end

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_WAIT: begin
        if (tmrZero) begin
          stb.issuePre = 1'b1;
          stb.ldTimer  = 1'b1;
          stb.tmrSel   = TSEL_RP;
          stateD       = ST_RP;
        end
      end
      ST_RP: begin
        if (tmrZero) begin
          stb.issueRef = 1'b1;
          stb.ldTimer  = 1'b1;
          stb.tmrSel   = TSEL_RC;
          stb.initLoad = 1'b1;
          stateD       = ST_RC;
        end
      end
      ST_RC: begin
        if (tmrZero) begin
          stb.ldTimer = 1'b1;
          if (initLast) begin
            stb.issueMrs = 1'b1;
            stb.tmrSel   = TSEL_MRD;
            stateD       = ST_MRD;
          end else begin
            stb.issueRef = 1'b1;
            stb.tmrSel   = TSEL_RC;
            stb.initDec  = 1'b1;
          end
        end
      end
      ST_MRD: begin
        if (tmrZero) begin
          stb.setDone = 1'b1;
          stateD      = ST_RUN;
        end
      end
      ST_RUN: begin
        stb.runEn = 1'b1;
        if (owedNz && refGrant && tmrZero) begin
          stb.issueRef = 1'b1;
          stb.takeRef  = 1'b1;
          stb.ldTimer  = 1'b1;
          stb.tmrSel   = TSEL_RC;
        end
      end
      default: stateD = ST_WAIT;
    endcase
  end

endmodule

// File: rtl/sdr_seq_dpath.sv
module sdr_seq_dpath
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int WAIT_CYC  = 1000,
  parameter int TRP       = 3,
  parameter int TRC       = 8,
  parameter int TMRD      = 2,
  parameter int INIT_REFS = 8,
  parameter int REF_IVL   = 1562,
  parameter int MAX_OWED  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       stb,
  input  logic [MODE_W-1:0] modeWord,
  output logic              tmrZero,
  output logic              initLast,
  output logic              owedNz,
  output logic [3:0]        cmdBus,
  output logic [ADDR_W-1:0] addrBus,
  output logic              initDone
);

  localparam int TMAX  = maxOf(maxOf(WAIT_CYC - 1, TRP), maxOf(TRC, TMRD));
  localparam int TMR_W = (TMAX < 1) ? 1 : $clog2(TMAX + 1);
  localparam int INI_W = (INIT_REFS < 2) ? 1 : $clog2(INIT_REFS);
  localparam int IVL_W = (REF_IVL < 2) ? 1 : $clog2(REF_IVL);
  localparam int OWE_W = $clog2(MAX_OWED + 1);
  localparam logic [MODE_W-1:0] RSV_MASK = MODE_W'(10'b01_1000_0000);

  // wait timer shared by every phase
  logic [TMR_W-1:0] timerQ;
  always_ff @(posedge clk) begin
    if (!rstN) timerQ <= TMR_W'(WAIT_CYC - 1);
    else if (stb.ldTimer) begin
      unique case (stb.tmrSel)
        TSEL_RP:  timerQ <= TMR_W'(TRP);
        TSEL_RC:  timerQ <= TMR_W'(TRC - 1);
        default:  timerQ <= TMR_W'(TMRD - 1);
      endcase
    end else if (timerQ != '0) timerQ <= timerQ - 1'b1;
  end
  assign tmrZero = (timerQ == '0);

  // start-up refresh counter
  logic [INI_W-1:0] initLeftQ;
  always_ff @(posedge clk) begin
    if (!rstN)             initLeftQ <= '0;
    else if (stb.initLoad) initLeftQ <= INI_W'(INIT_REFS - 1);
    else if (stb.initDec)  initLeftQ <= initLeftQ - 1'b1;
  end
  assign initLast = (initLeftQ == '0);

  // refresh period counter
  logic [IVL_W-1:0] ivlQ;
  logic             ivlZero, tick;
  assign ivlZero = (ivlQ == '0);
  assign tick    = stb.runEn && ivlZero;
  always_ff @(posedge clk) begin
    if (!rstN)                     ivlQ <= IVL_W'(REF_IVL - 1);
    else if (stb.setDone || tick)  ivlQ <= IVL_W'(REF_IVL - 1);
    else if (stb.runEn)            ivlQ <= ivlQ - 1'b1;
  end

  // owed refresh count, saturating
  logic [OWE_W-1:0] owedQ, owedD;
  logic [OWE_W:0]   owedSum;
  always_comb begin
    owedSum = {1'b0, owedQ} + {{OWE_W{1'b0}}, tick} - {{OWE_W{1'b0}}, stb.takeRef};
    if (owedSum > (OWE_W + 1)'(MAX_OWED)) owedD = OWE_W'(MAX_OWED);
    else                                   owedD = owedSum[OWE_W-1:0];
  end
  always_ff @(posedge clk) begin
    if (!rstN) owedQ <= '0;
    else       owedQ <= owedD;
  end
  assign owedNz = (owedQ != '0);

  // address images for precharge-all and mode load
  logic [MODE_W-1:0] modeMasked;
  logic [ADDR_W-1:0] mrsAddr, apAddr;
  assign modeMasked = modeWord & ~RSV_MASK;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
    if (i < MODE_W) begin : g_mode
      assign mrsAddr[i] = modeMasked[i];
    end else begin : g_zero
      assign mrsAddr[i] = 1'b0;
    end
    assign apAddr[i] = (i == AP_BIT);
  end

  // registered pins
  logic [3:0]        cmdQ;
  logic [ADDR_W-1:0] addrQ;
  logic              doneQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      doneQ <= 1'b0;
    end else begin
      if (stb.issuePre) begin
        cmdQ  <= CMD_PRE;
        addrQ <= apAddr;
      end else if (stb.issueMrs) begin
        cmdQ  <= CMD_MRS;
        addrQ <= mrsAddr;
      end else if (stb.issueRef) begin
        cmdQ  <= CMD_REF;
        addrQ <= '0;
      end else begin
        cmdQ  <= CMD_NOP;
        addrQ <= '0;
      end
      if (stb.setDone) doneQ <= 1'b1;
    end
  end

  assign cmdBus   = cmdQ;
  assign addrBus  = addrQ;
  assign initDone = doneQ;

endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int CLK_KHZ   = 100_000,
  parameter int WAIT_CYC  = CLK_KHZ * 200,
  parameter int TRP       = 3,
  parameter int TRC       = 8,
  parameter int TMRD      = 2,
  parameter int INIT_REFS = 8,
  parameter int REF_IVL   = (CLK_KHZ * 64) / 4096,
  parameter int MAX_OWED  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [9:0]        modeWord,
  input  logic              refGrant,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone,
  output logic              refReq
);

  seq_strobe_t stb;
  logic        tmrZero, initLast, owedNz;
  logic [3:0]  cmdBus;

  sdr_seq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tmrZero  (tmrZero),
    .initLast (initLast),
    .owedNz   (owedNz),
    .refGrant (refGrant),
    .stb      (stb)
  );

  sdr_seq_dpath #(
    .ADDR_W    (ADDR_W),
    .WAIT_CYC  (WAIT_CYC),
    .TRP       (TRP),
    .TRC       (TRC),
    .TMRD      (TMRD),
    .INIT_REFS (INIT_REFS),
    .REF_IVL   (REF_IVL),
    .MAX_OWED  (MAX_OWED)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .modeWord (modeWord),
    .tmrZero  (tmrZero),
    .initLast (initLast),
    .owedNz   (owedNz),
    .cmdBus   (cmdBus),
    .addrBus  (addr),
    .initDone (initDone)
  );

  assign {csN, rasN, casN, weN} = cmdBus;
  assign refReq = owedNz;

endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
  parameter int ADDR_W = 14,
  parameter int TRC    = 8,
  parameter int TMRD   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [ADDR_W-1:0] addr,
  input logic              initDone,
  input logic              refReq,
  input logic              refGrant
);

  logic [3:0] cmd;
  logic       isRef, isMrs, isPre;
  assign cmd   = {csN, rasN, casN, weN};
  assign isRef = (cmd == 4'b0001);
  assign isMrs = (cmd == 4'b0000);
  assign isPre = (cmd == 4'b0010);

  logic [15:0] sinceRef, sinceMrs;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRef <= 16'hFFFF;
      sinceMrs <= 16'hFFFF;
    end else begin
      if (isRef) sinceRef <= 16'd1;
      else if (sinceRef != 16'hFFFF) sinceRef <= sinceRef + 16'd1;
      if (isMrs) sinceMrs <= 16'd1;
      else if (sinceMrs != 16'hFFFF) sinceMrs <= sinceMrs + 16'd1;
    end
  end

  p_pre_ap_r2: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> (addr == ADDR_W'(1 << 10)));

  p_ref_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    isRef |-> (32'(sinceRef) >= TRC));

  p_mrs_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    isMrs |-> (32'(sinceRef) == TRC));

  p_mrs_rsv_r4: assert property (@(posedge clk) disable iff (!rstN)
    isMrs |-> (addr[8:7] == 2'b00 && (addr >> 10) == '0));

  p_done_delay_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> (32'(sinceMrs) == TMRD));

  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refGrant) |=> refReq);

  p_ref_granted_r9: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && isRef) |-> ($past(refReq) && $past(refGrant)));

endmodule

bind sdram_init_refresh sdr_seq_checker #(
  .ADDR_W (ADDR_W),
  .TRC    (TRC),
  .TMRD   (TMRD)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .addr     (addr),
  .initDone (initDone),
  .refReq   (refReq),
  .refGrant (refGrant)
);

// File: tb/sdram_init_refresh_test.sv
`timescale 1ns/1ps
module sdram_init_refresh_test;

  localparam int ADDR_W = 14;
  localparam int W      = 20;
  localparam int TRP    = 3;
  localparam int TRC    = 6;
  localparam int TMRD   = 2;
  localparam int NREF   = 8;
  localparam int IVL    = 60;
  localparam int MAXO   = 8;
  localparam logic [9:0] MODE = 10'b11_1011_0101;

  logic clk = 1'b0;
  logic rstN, refGrant;
  logic [9:0] modeWord;
  logic csN, rasN, casN, weN, initDone, refReq;
  logic [ADDR_W-1:0] addr;

  always #10 clk = ~clk;

  sdram_init_refresh #(
    .ADDR_W(ADDR_W), .WAIT_CYC(W), .TRP(TRP), .TRC(TRC), .TMRD(TMRD),
    .INIT_REFS(NREF), .REF_IVL(IVL), .MAX_OWED(MAXO)
  ) uut (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .refGrant(refGrant),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .addr(addr),
    .initDone(initDone), .refReq(refReq)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // bench-side schedule
  localparam int R0  = W + TRP + 1;
  localparam int M   = R0 + NREF * TRC;
  localparam int DN  = M + TMRD;
  localparam int END_CYC = DN - 1 + 13 * IVL + 600;

  function automatic int tickAt(input int k);
    return DN - 1 + k * IVL;
  endfunction

  function automatic logic [ADDR_W-1:0] mrsImage(input logic [9:0] m);
    logic [ADDR_W-1:0] a;
    a = '0;
    for (int i = 0; i < 10; i++) if (i != 7 && i != 8) a[i] = m[i];
    return a;
  endfunction

  initial begin
    int cyc, owed, lastTake, refCount;
    logic prevTake, take, tick, g;
    logic [3:0] expCmd, actCmd;
    logic [ADDR_W-1:0] expAddr;
    logic [15:0] lfsr;
    string tag;

    rstN = 1'b0; refGrant = 1'b1; modeWord = MODE;
    repeat (4) begin
      @(negedge clk);
      chk("R1 reset cmd", 32'({csN, rasN, casN, weN}), 32'h7);
      chk("R1 reset addr", 32'(addr), 32'h0);
      chk("R1 reset done", 32'(initDone), 32'h0);
      chk("R1 reset req", 32'(refReq), 32'h0);
    end
    rstN = 1'b1;
    cyc = 0; owed = 0; lastTake = -100000; prevTake = 1'b0;
    refCount = 0; lfsr = 16'hACE1;

    while (cyc <= END_CYC) begin
      // expected pins for this cycle
      expAddr = '0;
      if (cyc == W) begin
        expCmd = 4'b0010; expAddr = ADDR_W'(1 << 10); tag = "R2";
      end else if (cyc >= R0 && cyc < M && (cyc - R0) % TRC == 0) begin
        expCmd = 4'b0001; tag = "R3";
      end else if (cyc == M) begin
        expCmd = 4'b0000; expAddr = mrsImage(MODE); tag = "R4";
      end else if (prevTake) begin
        expCmd = 4'b0001; tag = "R9";
      end else begin
        expCmd = 4'b0111;
        tag = (cyc < W) ? "R1" : ((cyc < DN) ? "R6" : "R9");
      end
      actCmd = {csN, rasN, casN, weN};
      chk({tag, " cmd"}, 32'(actCmd), 32'(expCmd));
      chk({tag, " addr"}, 32'(addr), 32'(expAddr));
      chk("R5 initDone", 32'(initDone), 32'(cyc >= DN));
      chk((cyc < DN + IVL + 1) ? "R7 refReq" : "R8 refReq", 32'(refReq), 32'(owed > 0));

      // directed checks at the ports
      if (cyc >= tickAt(10) + 2 && cyc <= tickAt(10) + 51 && actCmd == 4'b0001) refCount++;
      if (cyc == tickAt(10) + 51) begin
        chk("R10 drained refreshes", 32'(refCount), 32'(MAXO));
        chk("R10 request cleared", 32'(refReq), 32'h0);
        refCount = 0;
      end
      if (cyc == tickAt(13) + 1) chk("R11 request kept", 32'(refReq), 32'h1);
      if (cyc >= tickAt(13) + 1 && cyc <= tickAt(13) + 21 && actCmd == 4'b0001) refCount++;
      if (cyc == tickAt(13) + 21) chk("R11 refreshes after coincident grant", 32'(refCount), 32'd3);

      // grant stimulus
      if (cyc < DN)                          g = 1'b1;
      else if (cyc <= tickAt(10))            g = 1'b0;
      else if (cyc <= tickAt(10) + 50)       g = 1'b1;
      else if (cyc < tickAt(13))             g = 1'b0;
      else if (cyc == tickAt(13))            g = 1'b1;
      else if (cyc <= tickAt(13) + 20)       g = 1'b1;
      else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        g = lfsr[0] & lfsr[3];
      end
      refGrant = g;

      // reference model step
      tick = (cyc >= DN - 1 + IVL) && ((cyc - (DN - 1)) % IVL == 0);
      take = (cyc >= DN) && g && (owed > 0) && (cyc - lastTake >= TRC);
      if (take) lastTake = cyc;
      owed = owed + int'(tick) - int'(take);
      if (owed > MAXO) owed = MAXO;
      prevTake = take;

      @(negedge clk);
      cyc++;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule